// File: doc/BRIEF.md
# Flash command controller

This block sits between a CPU register port and an on-chip nonvolatile memory array. Software writes one 16-bit control word. The word holds a start bit, a write-enable bit, a sticky sequence-error flag, an erase-select bit and a 6-bit operation code. When software sets the start bit, the block checks the request. A legal request is sent to the array as a single-cycle command strobe. The strobe carries an operation type, a row count and the target address, which is taken from the current address pointer. The block then waits for the array to report completion, or for an internal self-timing interval to run out, whichever comes first. Hardware then clears the start bit. An illegal request launches nothing. It raises the error flag instead.

The sequencer has four states:
- `ST_IDLE`: no operation is in progress.
- `ST_CHECK`: the one cycle in which the request is judged.
- `ST_LAUNCH`: the strobe cycle.
- `ST_WAIT`: waiting for completion.

It has six transitions:
- start: IDLE→CHECK
- accept: CHECK→LAUNCH
- reject: CHECK→IDLE
- issue: LAUNCH→WAIT
- complete: WAIT→IDLE
- stay: every other case

Two operation codes erase the whole memory or the boot region. They are accepted only while the external-programming-mode input is high.

Top module: `nvm_cmd_ctrl`

## Requirements
- R1: The read word is {start[15], wren[14], err[13], six zero bits 12:7, erase_sel[6], opcode[5:0]}. After reset every bit reads 0 and busy and arr_cmd are 0.
- R2: Writing 1 to bit 15 while idle sets the start bit, and busy equals the start bit. Software can never clear it. It returns to 0 only at a reject or a completion.
- R3: While wren is 0, a start launches no array command and is rejected.
- R4: Codes 011000, 011001 and 011010 give arr_rows 1, 2 and 4. arr_op is 1 (program rows) when erase_sel is 0 and 2 (erase rows) when erase_sel is 1. Code 011011 is a no-op.
- R5: With erase_sel 1, codes 0011xx give arr_op 3 (general block erase) and codes 0101xx give arr_op 4 (configuration erase), both with arr_rows 0. With erase_sel 0, every code outside R4 is a no-op.
- R6: With erase_sel 1, codes 1001xx give arr_op 5 (full erase) and codes 1010xx give arr_op 6 (boot erase). Each is legal only while ext_prog_mode is 1 and is a no-op otherwise.
- R7: A start with a no-op code, or with wren 0, never pulses arr_cmd. At the second rising edge after the write, err becomes 1 and the start bit becomes 0.
- R8: A legal start pulses arr_cmd for exactly one cycle, beginning at the second rising edge after the write. arr_op and arr_rows come from R4 to R6, and arr_addr is the ptr_addr sampled in the cycle after the write.
- R9: In the cycles after the strobe, the start bit is cleared at the edge after arr_done is high. It is also cleared TIMER_CYCLES edges after the first wait cycle if arr_done stays low. err is left unchanged.
- R10: While busy, a write leaves wren, erase_sel and opcode unchanged. A write with bit 15 set while busy sets err.
- R11: A write with bit 13 at 0 clears err, and writing 1 to bit 13 never sets it. When a hardware set and a software clear fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write data |
| reg_rdata | output | 16 | Control word read data |
| ext_prog_mode | input | 1 | External programming mode is active |
| ptr_addr | input | ADDR_W | Current address pointer |
| arr_done | input | 1 | Array reports the operation finished |
| busy | output | 1 | An operation is pending or running |
| arr_cmd | output | 1 | Single-cycle command strobe to the array |
| arr_op | output | 3 | Operation type sent with the strobe |
| arr_rows | output | 3 | Row count for row operations, else 0 |
| arr_addr | output | ADDR_W | Target address latched for the strobe |

## Verification
Two functions can fall in the same cycle: a hardware set of the error flag and a software clear of it. The bench provokes this while an operation is running, with one write that tries to set the start bit and also writes 0 to the error bit. The flag must read 1 afterwards, and the start bit and the locked fields must be unchanged. The rest of the bench sweeps every operation code against both erase-select values and both mode levels. It compares the strobe, the operation type, the row count and the address against a model written from the requirements, and it also exercises timer completion and the write-enable block.

// File: rtl/nvm_cmd_pkg.sv
package nvm_cmd_pkg;

    localparam int CTRL_W   = 16;
    localparam int CODE_W   = 6;
    localparam int ROWS_W   = 3;
    localparam int OP_W     = 3;

    localparam int BIT_START = 15;
    localparam int BIT_WREN  = 14;
    localparam int BIT_ERR   = 13;
    localparam int BIT_ERASE = 6;

    typedef enum logic [OP_W-1:0] {
        OP_NONE       = 3'd0,
        OP_PROG_ROWS  = 3'd1,
        OP_ERASE_ROWS = 3'd2,
        OP_ERASE_GEN  = 3'd3,
        OP_ERASE_CFG  = 3'd4,
        OP_ERASE_ALL  = 3'd5,
        OP_ERASE_BOOT = 3'd6
    } nvm_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CHECK  = 2'd1,
        ST_LAUNCH = 2'd2,
        ST_WAIT   = 2'd3
    } seq_state_e;

endpackage

// File: rtl/nvm_cmd_decode.sv
module nvm_cmd_decode
    import nvm_cmd_pkg::*;
#(
    parameter int CODE_BITS = CODE_W,
    parameter int ROW_BITS  = ROWS_W
) (
    input  logic                 erase_sel,
    input  logic [CODE_BITS-1:0] code,
    input  logic                 ext_mode,
    output nvm_op_e              op,
    output logic [ROW_BITS-1:0]  rows
);
    localparam logic [3:0] GRP_ROWS = 4'b0110;
    localparam logic [3:0] GRP_GEN  = 4'b0011;
    localparam logic [3:0] GRP_CFG  = 4'b0101;
    localparam logic [3:0] GRP_ALL  = 4'b1001;
    localparam logic [3:0] GRP_BOOT = 4'b1010;

    logic [3:0] grp;
    logic [1:0] sub;

    assign grp = code[CODE_BITS-1 -: 4];
    assign sub = code[1:0];

    always_comb begin
        op   = OP_NONE;
        rows = '0;
        if (grp == GRP_ROWS && sub != 2'b11) begin
            op   = erase_sel ? OP_ERASE_ROWS : OP_PROG_ROWS;
            rows = ROW_BITS'(1) << sub;
        end else if (erase_sel) begin
            unique case (grp)
                GRP_GEN:  op = OP_ERASE_GEN;
                GRP_CFG:  op = OP_ERASE_CFG;
                GRP_ALL:  op = ext_mode ? OP_ERASE_ALL  : OP_NONE;
                GRP_BOOT: op = ext_mode ? OP_ERASE_BOOT : OP_NONE;
                default:  op = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/nvm_op_timer.sv
module nvm_op_timer #(
    parameter int CYCLES = 6,
    localparam int CNT_W = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    logic [CNT_W-1:0] cnt_q;

    assign expired = run && (cnt_q == CNT_W'(CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run && !expired) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/nvm_cmd_seq.sv
module nvm_cmd_seq
    import nvm_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_set,
    input  logic       legal,
    input  logic       done,
    output seq_state_e state,
    output logic       accept,
    output logic       reject,
    output logic       launch,
    output logic       waiting,
    output logic       finish
);
    seq_state_e st_q;
    seq_state_e st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (start_set) st_d = ST_CHECK;
            ST_CHECK:  st_d = legal ? ST_LAUNCH : ST_IDLE;
            ST_LAUNCH: st_d = ST_WAIT;
            ST_WAIT:   if (done) st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept  = 1'b0;
        reject  = 1'b0;
        launch  = 1'b0;
        waiting = 1'b0;
        finish  = 1'b0;
        unique case (st_q)
            ST_IDLE:   ;
            ST_CHECK:  begin
                accept = legal;
                reject = !legal;
            end
            ST_LAUNCH: launch = 1'b1;
            ST_WAIT:   begin
                waiting = 1'b1;
                finish  = done;
            end
            default:   ;
        endcase
    end

    assign state = st_q;
endmodule

// File: rtl/nvm_cmd_ctrl.sv
module nvm_cmd_ctrl
    import nvm_cmd_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int TIMER_CYCLES = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              ext_prog_mode,
    input  logic [ADDR_W-1:0] ptr_addr,
    input  logic              arr_done,
    output logic              busy,
    output logic              arr_cmd,
    output logic [2:0]        arr_op,
    output logic [2:0]        arr_rows,
    output logic [ADDR_W-1:0] arr_addr
);
    logic              start_q;
    logic              wren_q;
    logic              err_q;
    logic              erase_q;
    logic [CODE_W-1:0] code_q;

    nvm_op_e           dec_op;
    logic [ROWS_W-1:0] dec_rows;
    nvm_op_e           op_q;
    logic [ROWS_W-1:0] rows_q;
    logic [ADDR_W-1:0] addr_q;

    seq_state_e        state;
    logic              accept, reject, launch, waiting, finish;
    logic              tmr_expired;
    logic              done;
    logic              idle_wr;
    logic              start_set;
    logic              restart_try;
    logic              unused_wbits;

    assign unused_wbits = ^reg_wdata[12:7];

    assign idle_wr     = reg_wr && !start_q;
    assign start_set   = idle_wr && reg_wdata[BIT_START];
    assign restart_try = reg_wr && start_q && reg_wdata[BIT_START];

    nvm_cmd_decode #(
        .CODE_BITS (CODE_W),
        .ROW_BITS  (ROWS_W)
    ) u_decode (
        .erase_sel (erase_q),
        .code      (code_q),
        .ext_mode  (ext_prog_mode),
        .op        (dec_op),
        .rows      (dec_rows)
    );

    nvm_cmd_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_set (start_set),
        .legal     (wren_q && (dec_op != OP_NONE)),
        .done      (done),
        .state     (state),
        .accept    (accept),
        .reject    (reject),
        .launch    (launch),
        .waiting   (waiting),
        .finish    (finish)
    );

    generate
        if (TIMER_CYCLES > 0) begin : g_timer
            nvm_op_timer #(
                .CYCLES (TIMER_CYCLES)
            ) u_timer (
                .clk     (clk),
                .rst_n   (rst_n),
                .clear   (launch),
                .run     (waiting),
                .expired (tmr_expired)
            );
        end else begin : g_no_timer
            assign tmr_expired = 1'b0;
        end
    endgenerate

    assign done = waiting && (arr_done || tmr_expired);

    // Control word fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            wren_q  <= 1'b0;
            erase_q <= 1'b0;
            code_q  <= '0;
        end else begin
            if (idle_wr) begin
                wren_q  <= reg_wdata[BIT_WREN];
                erase_q <= reg_wdata[BIT_ERASE];
                code_q  <= reg_wdata[CODE_W-1:0];
            end
            if (start_set) begin
                start_q <= 1'b1;
            end else if (reject || finish) begin
                start_q <= 1'b0;
            end
        end
    end

    // Error flag: hardware set has priority over a software clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (reject || restart_try) begin
            err_q <= 1'b1;
        end else if (reg_wr && !reg_wdata[BIT_ERR]) begin
            err_q <= 1'b0;
        end
    end

    // Command capture at the accept transition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_NONE;
            rows_q <= '0;
            addr_q <= '0;
        end else if (accept) begin
            op_q   <= dec_op;
            rows_q <= dec_rows;
            addr_q <= ptr_addr;
        end
    end

    assign reg_rdata = {start_q, wren_q, err_q, 6'b000000, erase_q, code_q};
    assign busy      = start_q;
    assign arr_cmd   = (state == ST_LAUNCH);
    assign arr_op    = op_q;
    assign arr_rows  = rows_q;
    assign arr_addr  = addr_q;
endmodule

// File: rtl/nvm_cmd_ctrl_chk.sv
module nvm_cmd_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [15:0] reg_wdata,
    input logic [15:0] reg_rdata,
    input logic        busy,
    input logic        arr_cmd,
    input logic [2:0]  arr_op
);
    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        arr_cmd |=> !arr_cmd);

    assert_strobe_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        arr_cmd |-> (reg_rdata[14] && busy));

    assert_strobe_real_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
        arr_cmd |-> (arr_op != 3'd0));

    assert_idle_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !arr_cmd);

    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[13] && !(reg_wr && !reg_wdata[13])) |=> reg_rdata[13]);

    assert_busy_fields_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr) |=> ((reg_rdata[14] == $past(reg_rdata[14]))
                              && (reg_rdata[6:0] == $past(reg_rdata[6:0]))));

    assert_busy_restart_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_wdata[15]) |=> reg_rdata[13]);
endmodule

bind nvm_cmd_ctrl nvm_cmd_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .arr_cmd   (arr_cmd),
    .arr_op    (arr_op)
);

// File: tb/nvm_cmd_ctrl_test.sv
`timescale 1ns/1ps
module nvm_cmd_ctrl_test;
    localparam int AW = 8;
    localparam int TC = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic          ext_prog_mode = 1'b0;
    logic [AW-1:0] ptr_addr = '0;
    logic          arr_done = 1'b0;
    logic          busy;
    logic          arr_cmd;
    logic [2:0]    arr_op;
    logic [2:0]    arr_rows;
    logic [AW-1:0] arr_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    nvm_cmd_ctrl #(.ADDR_W(AW), .TIMER_CYCLES(TC)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr        (reg_wr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .ext_prog_mode (ext_prog_mode),
        .ptr_addr      (ptr_addr),
        .arr_done      (arr_done),
        .busy          (busy),
        .arr_cmd       (arr_cmd),
        .arr_op        (arr_op),
        .arr_rows      (arr_rows),
        .arr_addr      (arr_addr)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [15:0] d);
        reg_wr    = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    // Expected {op, rows} from the requirements
    function automatic logic [5:0] model(input logic e, input logic [5:0] c, input logic x);
        logic [2:0] op;
        logic [2:0] rows;
        int grp;
        int sub;
        op   = 3'd0;
        rows = 3'd0;
        grp  = int'(c) / 4;
        sub  = int'(c) % 4;
        if (grp == 6 && sub < 3) begin
            op   = e ? 3'd2 : 3'd1;
            rows = 3'(1 << sub);
        end else if (e) begin
            if (grp == 3) op = 3'd3;
            else if (grp == 5) op = 3'd4;
            else if (grp == 9 && x) op = 3'd5;
            else if (grp == 10 && x) op = 3'd6;
        end
        return {op, rows};
    endfunction

    function automatic string tag_of(input logic e, input logic [5:0] c);
        int grp;
        grp = int'(c) / 4;
        if (grp == 6) return "R4";
        if (e && (grp == 9 || grp == 10)) return "R6";
        return "R5";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [5:0]  exp_v;
        logic [15:0] w;
        string       tg;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(reg_rdata == 16'h0000 && !busy && !arr_cmd, "R1 reset",
              {reg_rdata, 14'b0, busy, arr_cmd}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep: erase_sel x mode x every code, write-enable on
        for (int e = 0; e < 2; e++) begin
            for (int x = 0; x < 2; x++) begin
                for (int c = 0; c < 64; c++) begin
                    ext_prog_mode = x[0];
                    ptr_addr      = AW'(c * 4 + e * 2 + x);
                    exp_v = model(e[0], 6'(c), x[0]);
                    tg    = tag_of(e[0], 6'(c));
                    write_word(16'h0000);
                    w = 16'hE000 | (16'(e) << 6) | 16'(c);
                    write_word(w);
                    check(reg_rdata == (w & 16'hDFFF) && busy, "R2 start set",
                          reg_rdata, w & 16'hDFFF);
                    @(negedge clk);
                    if (exp_v[5:3] != 3'd0) begin
                        check(arr_cmd && arr_op == exp_v[5:3] && arr_rows == exp_v[2:0]
                              && arr_addr == ptr_addr, {tg, " R8 launch"},
                              {arr_cmd, arr_op, arr_rows, arr_addr},
                              {1'b1, exp_v, ptr_addr});
                        @(negedge clk);
                        check(!arr_cmd && busy, "R8 strobe one cycle",
                              {arr_cmd, busy}, 2'b01);
                        arr_done = 1'b1;
                        @(negedge clk);
                        arr_done = 1'b0;
                        check(!busy && reg_rdata[15:13] == 3'b010, "R9 complete on done",
                              reg_rdata[15:13], 3'b010);
                    end else begin
                        check(!arr_cmd && !busy && reg_rdata[13], {tg, " R7 reject"},
                              {arr_cmd, busy, reg_rdata[13]}, 3'b001);
                    end
                end
            end
        end
        ext_prog_mode = 1'b0;

        // R3: write-enable low blocks a legal code
        write_word(16'h0000);
        write_word(16'h8018);
        @(negedge clk);
        check(!arr_cmd && !busy && reg_rdata[13], "R3 wren blocks",
              {arr_cmd, busy, reg_rdata[13]}, 3'b001);

        // R11: clear by 0, no set by 1
        write_word(16'h0000);
        check(!reg_rdata[13], "R11 clear by zero", reg_rdata[13], 0);
        write_word(16'h2000);
        check(!reg_rdata[13], "R11 one does not set", reg_rdata[13], 0);

        // R9: timer completion with arr_done held low
        ptr_addr = 8'hA5;
        write_word(16'hC059);
        @(negedge clk);
        check(arr_cmd && arr_op == 3'd2 && arr_rows == 3'd2 && arr_addr == 8'hA5,
              "R8 erase two rows", {arr_cmd, arr_op, arr_rows, arr_addr},
              {1'b1, 3'd2, 3'd2, 8'hA5});
        repeat (TC) @(negedge clk);
        check(busy, "R9 still busy before timer end", busy, 1);
        @(negedge clk);
        check(!busy && !reg_rdata[13], "R9 timer completion", {busy, reg_rdata[13]}, 0);

        // R10 and R11: writes while busy, then set and clear in one cycle
        write_word(16'hC018);
        @(negedge clk);
        @(negedge clk);
        write_word(16'h207F);
        check(reg_rdata == 16'hC018, "R10 fields locked", reg_rdata, 16'hC018);
        write_word(16'h8000);
        check(reg_rdata == 16'hE018, "R11 set beats clear", reg_rdata, 16'hE018);
        arr_done = 1'b1;
        @(negedge clk);
        arr_done = 1'b0;
        check(reg_rdata == 16'h6018 && !busy, "R9 R10 finish keeps err",
              reg_rdata, 16'h6018);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule